// File: doc/BRIEF.md
# Bus Controller Retry and Poll Checker

This block decides what a bus controller does after each message it sends on a dual-redundant serial command/response bus. When a message ends, the block looks at how it ended: a clean reply, a reply with the busy bit set, a message error, or no reply inside the response window. From that outcome it either repeats the message or releases the message sequencer to the next one. A retry can go out on the same bus or on the other bus. The host sets which outcomes are worth a retry and the largest number of retries.

When the block moves on, it waits a host-set number of clock ticks before it signals the next message. It flags an interrupt when a message gives up after its allowed retries. In polling mode it also checks each good status reply against a compare word, under a mask. A mismatch raises a separate interrupt. Serial encoding, decoding and walking the message list are handled elsewhere. The message walker drives `rsp_arm` when a command goes out and `msg_end` when a reply has been decoded.

Top module: `bcr_retry_poll`

## Requirements
- R1: After reset, `retry_go`, `next_go`, `bus_sel`, `irq_poll` and `irq_exhaust` are all 0, and the retry count is zero.
- R2: Each outcome is classed in one of four ways. Time-out ranks highest, then message error (`msg_end` with `msg_err`), then busy (`msg_end` with `sts_word` bit 3 set), then clean. A retry is made only when the class has its own enable set (`en_retry_to`, `en_retry_err`, `en_retry_busy`). A clean reply never retries.
- R3: A message is retried at most min(`retry_limit`, 4) times. The count returns to zero whenever the block moves on to the next message.
- R4: On every retry, `bus_sel` inverts when `alt_bus` is 1 and holds its value when `alt_bus` is 0.
- R5: Suppose the class has its enable set but no retries remain, including a limit of 0. In that case `irq_exhaust` pulses for one cycle, the block moves on, and `bus_sel` takes the value of `home_bus`. Moving on for any other reason also loads `home_bus` into `bus_sel`, but does not raise `irq_exhaust`.
- R6: Say `rsp_arm` is sampled at clock edge a, and `msg_end` is not seen on edges a+1 through a+`rsp_window`. Then a time-out outcome is taken, and its decision appears at edge a+`rsp_window`+1. A `msg_end` seen before then cancels the time-out.
- R7: An interrupt is raised when `poll_mode` is 1 and a `msg_end` without `msg_err` carries a status word that differs from `poll_cmp` in any bit set in `poll_mask`. In that case `irq_poll` pulses in the cycle of the decision. Errored replies, time-outs and masked-off bits never raise it.
- R8: When the block moves on at edge k, `next_go` pulses for one cycle after edge k+1+`gap_delay`.
- R9: A retry decision for an outcome sampled at edge k makes `retry_go` high for exactly the one cycle after edge k. `retry_go` and `next_go` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsp_arm | input | 1 | Command sent; start the response window |
| msg_end | input | 1 | Reply received and decoded (one-cycle pulse) |
| msg_err | input | 1 | Reply had a message error (valid with msg_end) |
| sts_word | input | 16 | Received status word (valid with msg_end) |
| rsp_window | input | 8 | Response window in clock ticks (1 or more) |
| en_retry_busy | input | 1 | Retry on busy status |
| en_retry_err | input | 1 | Retry on message error |
| en_retry_to | input | 1 | Retry on response time-out |
| retry_limit | input | 3 | Largest number of retries (values above 4 act as 4) |
| alt_bus | input | 1 | Swap bus on each retry |
| home_bus | input | 1 | Bus used when a new message starts |
| poll_mode | input | 1 | Enable status-word compare |
| poll_cmp | input | 16 | Expected status word |
| poll_mask | input | 16 | Bits of the status word taking part in the compare |
| gap_delay | input | 8 | Intermessage delay in clock ticks |
| retry_go | output | 1 | Repeat the current message (pulse) |
| next_go | output | 1 | Start the next message (pulse) |
| bus_sel | output | 1 | Bus for the next transmission (0 or 1) |
| irq_poll | output | 1 | Poll compare mismatch (pulse) |
| irq_exhaust | output | 1 | Retries used up (pulse) |

## Verification
The assertions assume a well-behaved message walker. It sends at most one outcome per message. It does not pulse `msg_end` in the same cycle as a time-out, and it does not pulse it while an intermessage delay is running. It keeps `rsp_window` at 1 or above. Under these conditions, each `retry_go` relates to the bus and count state of the cycle before. The stimulus follows the same rules. Each message gets exactly one `msg_end` or one expiry, and the bench waits for the matching `retry_go` or `next_go` before it starts another. Settings change only while the block is idle.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int WORD_W    = 16;
  localparam int MAX_TRIES = 4;
  localparam int CNT_W     = $clog2(MAX_TRIES + 1);
  localparam int BUSY_BIT  = 3;

  typedef enum logic [1:0] {OC_CLEAN, OC_BUSY, OC_ERR, OC_TO} outcome_e;

  // Time-out outranks error, error outranks busy.
  function automatic outcome_e classify(input logic to, input logic err, input logic busy);
    if (to)        return OC_TO;
    else if (err)  return OC_ERR;
    else if (busy) return OC_BUSY;
    else           return OC_CLEAN;
  endfunction

  function automatic logic poll_miss(input logic [WORD_W-1:0] sts,
                                     input logic [WORD_W-1:0] cmp,
                                     input logic [WORD_W-1:0] mask);
    return |((sts ^ cmp) & mask);
  endfunction

  function automatic logic [CNT_W-1:0] cap_limit(input logic [CNT_W-1:0] lim);
    if (int'(lim) > MAX_TRIES) return CNT_W'(MAX_TRIES);
    return lim;
  endfunction
endpackage

// File: rtl/bcr_resp_timer.sv
module bcr_resp_timer #(
  parameter int WIN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             reply,
  input  logic [WIN_W-1:0] window,
  output logic             running,
  output logic             expired
);
  logic [WIN_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      running <= 1'b0;
      expired <= 1'b0;
    end else begin
      expired <= 1'b0;
      if (arm) begin
        cnt_q   <= '0;
        running <= 1'b1;
      end else if (running) begin
        if (reply) begin
          running <= 1'b0;
        end else if (cnt_q == window - 1'b1) begin
          expired <= 1'b1;
          running <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcr_gap_timer.sv
module bcr_gap_timer #(
  parameter int GAP_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [GAP_W-1:0] delay,
  output logic             fire
);
  logic [GAP_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      fire  <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (start) begin
        cnt_q <= delay;
        run_q <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == '0) begin
          fire  <= 1'b1;
          run_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bcr_judge.sv
module bcr_judge
  import bcr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  outcome_e         cause,
  input  logic             en_busy,
  input  logic             en_err,
  input  logic             en_to,
  input  logic [CNT_W-1:0] lim,
  input  logic             alt_bus,
  input  logic             home_bus,
  output logic             want,
  output logic             move_on,
  output logic [CNT_W-1:0] tries_q,
  output logic             retry_go,
  output logic             bus_sel,
  output logic             irq_exhaust
);
  logic can_retry;

  always_comb begin
    unique case (cause)
      OC_BUSY: want = en_busy;
      OC_ERR:  want = en_err;
      OC_TO:   want = en_to;
      default: want = 1'b0;
    endcase
    can_retry = tries_q < lim;
    move_on   = evt && !(want && can_retry);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tries_q     <= '0;
      retry_go    <= 1'b0;
      bus_sel     <= 1'b0;
      irq_exhaust <= 1'b0;
    end else begin
      retry_go    <= 1'b0;
      irq_exhaust <= 1'b0;
      if (evt) begin
        if (want && can_retry) begin
          retry_go <= 1'b1;
          tries_q  <= tries_q + 1'b1;
          if (alt_bus) bus_sel <= ~bus_sel;
        end else begin
          tries_q     <= '0;
          irq_exhaust <= want;
          bus_sel     <= home_bus;
        end
      end
    end
  end
endmodule

// File: rtl/bcr_retry_poll.sv
module bcr_retry_poll
  import bcr_pkg::*;
#(
  parameter int WIN_W = 8,
  parameter int GAP_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rsp_arm,
  input  logic                 msg_end,
  input  logic                 msg_err,
  input  logic [WORD_W-1:0]    sts_word,
  input  logic [WIN_W-1:0]     rsp_window,
  input  logic                 en_retry_busy,
  input  logic                 en_retry_err,
  input  logic                 en_retry_to,
  input  logic [CNT_W-1:0]     retry_limit,
  input  logic                 alt_bus,
  input  logic                 home_bus,
  input  logic                 poll_mode,
  input  logic [WORD_W-1:0]    poll_cmp,
  input  logic [WORD_W-1:0]    poll_mask,
  input  logic [GAP_W-1:0]     gap_delay,
  output logic                 retry_go,
  output logic                 next_go,
  output logic                 bus_sel,
  output logic                 irq_poll,
  output logic                 irq_exhaust
);
  // Named internal events, visible to the bound checker.
  logic             to_evt;
  logic             rsp_running;
  logic             evt;
  logic             good_reply;
  logic             want;
  logic             move_on;
  logic [CNT_W-1:0] tries_q;
  logic [CNT_W-1:0] lim_eff;
  outcome_e         cause;

  assign evt        = to_evt | msg_end;
  assign good_reply = msg_end && !msg_err;
  assign lim_eff    = cap_limit(retry_limit);
  assign cause      = classify(to_evt, msg_end && msg_err, good_reply && sts_word[BUSY_BIT]);

  bcr_resp_timer #(.WIN_W(WIN_W)) u_rsp (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (rsp_arm),
    .reply   (msg_end),
    .window  (rsp_window),
    .running (rsp_running),
    .expired (to_evt)
  );

  bcr_judge u_judge (
    .clk         (clk),
    .rst_n       (rst_n),
    .evt         (evt),
    .cause       (cause),
    .en_busy     (en_retry_busy),
    .en_err      (en_retry_err),
    .en_to       (en_retry_to),
    .lim         (lim_eff),
    .alt_bus     (alt_bus),
    .home_bus    (home_bus),
    .want        (want),
    .move_on     (move_on),
    .tries_q     (tries_q),
    .retry_go    (retry_go),
    .bus_sel     (bus_sel),
    .irq_exhaust (irq_exhaust)
  );

  bcr_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .start (move_on),
    .delay (gap_delay),
    .fire  (next_go)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq_poll <= 1'b0;
    else        irq_poll <= poll_mode && good_reply && poll_miss(sts_word, poll_cmp, poll_mask);
  end
endmodule

// File: rtl/bcr_retry_poll_chk.sv
module bcr_retry_poll_chk
  import bcr_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             msg_end,
  input logic             msg_err,
  input logic             poll_mode,
  input logic             alt_bus,
  input logic             home_bus,
  input logic             retry_go,
  input logic             next_go,
  input logic             bus_sel,
  input logic             irq_poll,
  input logic             irq_exhaust,
  input logic             to_evt,
  input logic             rsp_running,
  input logic             want,
  input logic [CNT_W-1:0] tries_q
);
  // R9
  excl_go_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(retry_go && next_go));

  // R3
  retry_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |-> (tries_q >= 1 && int'(tries_q) <= MAX_TRIES));

  // R4
  alt_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    retry_go |-> ((bus_sel != $past(bus_sel)) == $past(alt_bus)));

  // R7
  poll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_poll |-> $past(poll_mode && msg_end && !msg_err));

  // R5
  exhaust_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_exhaust |-> (!retry_go && bus_sel == $past(home_bus) && $past(want)));

  // R6
  to_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    to_evt |-> $past(rsp_running));
endmodule

bind bcr_retry_poll bcr_retry_poll_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_end     (msg_end),
  .msg_err     (msg_err),
  .poll_mode   (poll_mode),
  .alt_bus     (alt_bus),
  .home_bus    (home_bus),
  .retry_go    (retry_go),
  .next_go     (next_go),
  .bus_sel     (bus_sel),
  .irq_poll    (irq_poll),
  .irq_exhaust (irq_exhaust),
  .to_evt      (to_evt),
  .rsp_running (rsp_running),
  .want        (want),
  .tries_q     (tries_q)
);

// File: tb/sim_bcr_retry_poll.sv
`timescale 1ns/1ps
module sim_bcr_retry_poll;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rsp_arm = 0, msg_end = 0, msg_err = 0;
  logic [15:0] sts_word = '0;
  logic [7:0]  rsp_window = 8'd4;
  logic        en_retry_busy = 0, en_retry_err = 0, en_retry_to = 0;
  logic [2:0]  retry_limit = 3'd4;
  logic        alt_bus = 0, home_bus = 0, poll_mode = 0;
  logic [15:0] poll_cmp = '0, poll_mask = '0;
  logic [7:0]  gap_delay = '0;
  logic        retry_go, next_go, bus_sel, irq_poll, irq_exhaust;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  bcr_retry_poll u0 (.*);

  typedef struct packed {
    logic [2:0]  en;      // [2] busy, [1] error, [0] time-out
    logic        alt;
    logic [2:0]  lim;
    logic        poll;
    logic [15:0] mask;
    logic [15:0] cmp;
    logic        err;
    logic [15:0] sts;
    logic        x_retry;
    logic        x_bus;
    logic        x_poll;
    logic        x_exh;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{3'b111, 1'b0, 3'd4, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b100, 1'b1, 3'd4, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0008, 1'b1, 1'b1, 1'b0, 1'b0},
    '{3'b011, 1'b1, 3'd4, 1'b0, 16'h0000, 16'h0000, 1'b0, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b010, 1'b0, 3'd4, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b1, 1'b0, 1'b0, 1'b0},
    '{3'b010, 1'b1, 3'd0, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b1},
    '{3'b000, 1'b0, 3'd4, 1'b1, 16'h00FF, 16'h0012, 1'b0, 16'h3412, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b000, 1'b0, 3'd4, 1'b1, 16'h00FF, 16'h0012, 1'b0, 16'h0013, 1'b0, 1'b0, 1'b1, 1'b0},
    '{3'b000, 1'b0, 3'd4, 1'b1, 16'h0000, 16'hFFFF, 1'b0, 16'h0000, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b100, 1'b1, 3'd4, 1'b1, 16'hFFFF, 16'h0800, 1'b0, 16'h0808, 1'b1, 1'b1, 1'b1, 1'b0},
    '{3'b000, 1'b0, 3'd4, 1'b1, 16'h00FF, 16'h0012, 1'b1, 16'h0013, 1'b0, 1'b0, 1'b0, 1'b0},
    '{3'b100, 1'b0, 3'd4, 1'b0, 16'h0000, 16'h0000, 1'b1, 16'h0008, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Drives one outcome pulse; returns at the first sample point after the capturing edge.
  task automatic end_msg(input logic err, input logic [15:0] sts);
    @(negedge clk);
    msg_end = 1'b1; msg_err = err; sts_word = sts;
    @(negedge clk);
    msg_end = 1'b0; msg_err = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seen_retry;
    int seen_next;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 retry_go", retry_go, 0);
    chk("R1 next_go", next_go, 0);
    chk("R1 bus_sel", bus_sel, 0);
    chk("R1 irqs", {irq_poll, irq_exhaust}, 0);

    // Vector table: each entry starts from bus 0 and zero retries (R2 R4 R5 R7 R9)
    for (int i = 0; i < NV; i++) begin
      {en_retry_busy, en_retry_err, en_retry_to} = VEC[i].en;
      alt_bus = VEC[i].alt; retry_limit = VEC[i].lim; poll_mode = VEC[i].poll;
      poll_mask = VEC[i].mask; poll_cmp = VEC[i].cmp; home_bus = 1'b0;
      end_msg(VEC[i].err, VEC[i].sts);
      chk($sformatf("R2 R9 vec%0d retry_go", i), retry_go, VEC[i].x_retry);
      chk($sformatf("R4 vec%0d bus_sel", i), bus_sel, VEC[i].x_bus);
      chk($sformatf("R7 vec%0d irq_poll", i), irq_poll, VEC[i].x_poll);
      chk($sformatf("R5 vec%0d irq_exhaust", i), irq_exhaust, VEC[i].x_exh);
      chk($sformatf("R9 vec%0d next_go low", i), next_go, 0);
      if (VEC[i].x_retry) begin
        poll_mode = 1'b0;
        end_msg(1'b0, 16'h0000);
      end
      @(negedge clk);
      chk($sformatf("R8 vec%0d next_go", i), next_go, 1);
    end

    // R3 R4 R5: limit 4 with alternation, home bus 1
    {en_retry_busy, en_retry_err, en_retry_to} = 3'b010;
    alt_bus = 1; retry_limit = 3'd4; home_bus = 1; poll_mode = 0;
    for (int t = 1; t <= 4; t++) begin
      end_msg(1'b1, 16'h0);
      chk($sformatf("R3 try%0d retry_go", t), retry_go, 1);
      chk($sformatf("R4 try%0d bus_sel", t), bus_sel, t % 2);
    end
    end_msg(1'b1, 16'h0);
    chk("R3 fifth error no retry", retry_go, 0);
    chk("R5 exhaust irq", irq_exhaust, 1);
    chk("R5 bus back home", bus_sel, 1);
    @(negedge clk);
    chk("R5 moves on", next_go, 1);

    // R3 limit above four acts as four; R4 fixed bus
    alt_bus = 0; retry_limit = 3'd7; home_bus = 0;
    seen_retry = 0;
    for (int t = 1; t <= 5; t++) begin
      end_msg(1'b1, 16'h0);
      if (retry_go) seen_retry++;
      if (t <= 4) chk($sformatf("R4 fixed bus try%0d", t), bus_sel, 1);
    end
    chk("R3 capped retries", seen_retry, 4);
    chk("R5 capped exhaust", irq_exhaust, 1);
    @(negedge clk);

    // R3 count clears on moving on
    {en_retry_busy, en_retry_err, en_retry_to} = 3'b100;
    retry_limit = 3'd1;
    end_msg(1'b0, 16'h0008);
    chk("R3 first busy retry", retry_go, 1);
    end_msg(1'b0, 16'h0000);
    @(negedge clk);
    end_msg(1'b0, 16'h0008);
    chk("R3 count cleared retry again", retry_go, 1);
    end_msg(1'b0, 16'h0008);
    chk("R3 limit one exhaust", irq_exhaust, 1);
    @(negedge clk);

    // R8 intermessage delay
    gap_delay = 8'd5;
    end_msg(1'b0, 16'h0000);
    seen_next = 0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      if (next_go) seen_next++;
    end
    chk("R8 no early next_go", seen_next, 0);
    @(negedge clk);
    chk("R8 next_go after delay", next_go, 1);
    gap_delay = 8'd0;
    @(negedge clk);

    // R6 time-out timing with retry on alternate bus
    {en_retry_busy, en_retry_err, en_retry_to} = 3'b001;
    alt_bus = 1; retry_limit = 3'd4; home_bus = 0; rsp_window = 8'd4;
    @(negedge clk); rsp_arm = 1;
    @(negedge clk); rsp_arm = 0;
    seen_retry = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      if (retry_go) seen_retry++;
    end
    chk("R6 no early time-out", seen_retry, 0);
    @(negedge clk);
    chk("R6 time-out retry", retry_go, 1);
    chk("R4 time-out bus swap", bus_sel, 1);
    end_msg(1'b0, 16'h0);
    @(negedge clk);

    // R2 time-out without its enable moves on
    en_retry_to = 0;
    @(negedge clk); rsp_arm = 1;
    @(negedge clk); rsp_arm = 0;
    repeat (5) @(negedge clk);
    chk("R2 disabled time-out no retry", retry_go, 0);
    chk("R5 disabled no exhaust", irq_exhaust, 0);
    @(negedge clk);
    chk("R2 disabled time-out next", next_go, 1);

    // R6 reply cancels the window
    en_retry_to = 1;
    @(negedge clk); rsp_arm = 1;
    @(negedge clk); rsp_arm = 0;
    end_msg(1'b0, 16'h0000);
    seen_retry = 0; seen_next = 0;
    for (int c = 0; c < 10; c++) begin
      @(negedge clk);
      if (retry_go) seen_retry++;
      if (next_go) seen_next++;
    end
    chk("R6 cancelled no retry", seen_retry, 0);
    chk("R6 cancelled one next", seen_next, 1);

    finish_run();
  end
endmodule